// File: doc/BRIEF.md
# Programmable Watchdog Timer Register

This block is a processor-facing watchdog. Software programs one 8-bit configuration register over a simple single-cycle register bus. The upper five data bits below the top bit give a multiplier, and the low two bits pick a time step. The block counts a supplied 16 Hz tick pulse. When the multiplier times the step has passed with no access to the configuration register, the block raises a watchdog flag and, unless steering is set, an interrupt.

Any read or write of the configuration register counts as service and restarts the full period. A second register, the flag register, returns the watchdog flag and clears it as part of the read. A multiplier of zero turns the watchdog off, and the block leaves reset in that state. An unserviced watchdog reloads itself at expiry and keeps running, so it expires again one period later.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the configuration register reads 0x00, the watchdog flag is 0, `irq` is 0, and the watchdog is disabled.
- R2: In the configuration register (address 0), bits 6:2 are the multiplier M and bits 1:0 are the step code: 00 = 1 tick, 01 = 4 ticks, 10 = 16 ticks, 11 = 64 ticks. Expiry happens on the M×step-th tick after the last configuration access, and not before.
- R3: On expiry the watchdog flag becomes 1. If bit 7 of the configuration is 0, `irq` goes high in the same clock cycle.
- R4: With configuration bit 7 equal to 1, expiry sets the flag but `irq` stays low.
- R5: Any read or write of address 0 restarts the count, so the next expiry comes a full period after that access.
- R6: A read or write of address 0 drives `irq` low and leaves the flag unchanged.
- R7: A read of address 1 returns the flag in bit 0 and zeros in bits 7:1. The read then clears the flag and drives `irq` low.
- R8: A multiplier of 0 disables the watchdog whatever the step code and bit 7 are. This includes 0x00. No expiry occurs.
- R9: At expiry the count reloads by itself. If nothing accesses address 0, a second expiry follows one full period later.
- R10: Writes to address 1 have no effect. `bus_rdata` is 0x00 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle 16 Hz timebase pulse |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = configuration register, 1 = flag register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed |
| irq | output | 1 | Watchdog interrupt, active high |

## Verification
The hardest cases to reach are where service lands late in a period and where nobody services the timer after an expiry. To cover the first, the bench restarts the count with a read or a write a few ticks before expiry. It then counts exactly one tick short of a full period and one tick past it. To cover the second, the bench clears the flag through the flag register only, which leaves the count running, and checks that the next expiry lands exactly one period after the first. Vectors with long steps (64 ticks) and a large multiplier (31) exercise the upper end of the prescaler and the multiplier count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int MULT_W     = 5;
    localparam int RES_W      = 2;
    localparam int DATA_W     = 1 + MULT_W + RES_W;
    localparam int STEP_SHIFT = 2;
    localparam int PRESC_W    = STEP_SHIFT * ((1 << RES_W) - 1);

    typedef enum logic [RES_W-1:0] {
        RES_SIXTEENTH = 2'd0,
        RES_QUARTER   = 2'd1,
        RES_ONE       = 2'd2,
        RES_FOUR      = 2'd3
    } res_e;

    typedef enum logic {
        ADDR_CFG  = 1'b0,
        ADDR_FLAG = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        res_e              res;
    } wdt_cfg_t;

    // Last prescale count of a step: 4^code ticks per step, minus one.
    function automatic logic [PRESC_W-1:0] step_last(res_e r);
        int span;
        span = (1 << (STEP_SHIFT * int'(r))) - 1;
        return PRESC_W'(span);
    endfunction

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output wdt_cfg_t          cfg,
    output wdt_cfg_t          cfg_next,
    output logic              cfg_access,
    output logic              flag_read,
    output logic [DATA_W-1:0] rdata
);

    reg_addr_e sel_addr;
    logic      cfg_write;

    assign sel_addr   = reg_addr_e'(addr);
    assign cfg_access = sel && (sel_addr == ADDR_CFG);
    assign cfg_write  = cfg_access && wr;
    assign flag_read  = sel && !wr && (sel_addr == ADDR_FLAG);
    assign cfg_next   = cfg_write ? wdt_cfg_t'(wdata) : cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            cfg <= cfg_next;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (sel_addr == ADDR_CFG) begin
                rdata = cfg;
            end else begin
                rdata = {{(DATA_W-1){1'b0}}, flag};
            end
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  res_e res,
    output logic unit_done
);

    logic [PRESC_W-1:0] cnt;
    logic               at_last;

    assign at_last   = (cnt == step_last(res));
    assign unit_done = tick && !restart && at_last;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (at_last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [MULT_W-1:0] load_mult,
    input  logic [MULT_W-1:0] run_mult,
    input  logic              unit_done,
    output logic              expire
);

    logic [MULT_W-1:0] remaining;

    assign expire = unit_done && (remaining == MULT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (restart) begin
            remaining <= load_mult;
        end else if (expire) begin
            remaining <= run_mult;
        end else if (unit_done && (remaining != '0)) begin
            remaining <= remaining - 1'b1;
        end
    end

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    wdt_cfg_t cfg_cur;
    wdt_cfg_t cfg_nxt;
    logic     cfg_access;
    logic     flag_read;
    logic     unit_done;
    logic     expire;
    logic     wf_q;

    wdt_regif u_regif (
        .clk        (clk),
        .rst        (rst),
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .flag       (wf_q),
        .cfg        (cfg_cur),
        .cfg_next   (cfg_nxt),
        .cfg_access (cfg_access),
        .flag_read  (flag_read),
        .rdata      (bus_rdata)
    );

    wdt_prescaler u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .restart   (cfg_access),
        .res       (cfg_cur.res),
        .unit_done (unit_done)
    );

    wdt_countdown u_count (
        .clk       (clk),
        .rst       (rst),
        .restart   (cfg_access),
        .load_mult (cfg_nxt.mult),
        .run_mult  (cfg_cur.mult),
        .unit_done (unit_done),
        .expire    (expire)
    );

    // An expiry wins over a flag read in the same cycle, so no timeout is lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            wf_q <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (expire) begin
                wf_q <= 1'b1;
            end else if (flag_read) begin
                wf_q <= 1'b0;
            end
            if (expire && !cfg_cur.steer) begin
                irq <= 1'b1;
            end else if (cfg_access || flag_read) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       wr,
    input logic       addr,
    input logic [7:0] cfg,
    input logic       wf,
    input logic       irq,
    input logic       expire
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == 8'h00 && !wf && !irq)); // R1

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> wf); // R3

    AST_STEER_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !cfg[7]); // R4

    AST_CFG_ACCESS_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (sel && !addr) |=> !irq); // R6

    AST_CFG_ACCESS_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (sel && !addr && wf) |=> wf); // R6

    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr && addr && !expire) |=> (!wf && !irq)); // R7

    AST_ZERO_MULT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cfg[6:2] == 5'd0 && !wf) |=> !wf); // R8

    AST_FLAG_WRITE_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr && !wf && !expire) |=> !wf); // R10

endmodule

bind tick_watchdog wdt_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .cfg    (cfg_cur),
    .wf     (wf_q),
    .irq    (irq),
    .expire (expire)
);

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] rd;

    always #5 clk = ~clk;

    tick_watchdog u_tick_watchdog (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {config, ticks to expiry, expected irq}
    localparam logic [23:0] VECS [6] = '{
        {8'h04, 8'd1,  8'd1},
        {8'h0E, 8'd48, 8'd1},
        {8'h09, 8'd8,  8'd1},
        {8'h07, 8'd64, 8'd1},
        {8'h85, 8'd4,  8'd0},
        {8'h7C, 8'd31, 8'd1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        bus_read(1'b0, rd); check("R1 cfg", rd, 8'h00);
        bus_read(1'b1, rd); check("R1 flag", rd, 8'h00);
        ticks(70);
        check("R1 disabled irq", {7'd0, irq}, 8'h00);

        // R2 R3 R4 vector table
        for (int v = 0; v < 6; v++) begin
            bus_read(1'b1, rd);
            bus_write(1'b0, VECS[v][23:16]);
            ticks(int'(VECS[v][15:8]) - 1);
            check("R2 early irq", {7'd0, irq}, 8'h00);
            ticks(1);
            if (VECS[v][0]) check("R3 irq at expiry", {7'd0, irq}, 8'h01);
            else            check("R4 steered irq low", {7'd0, irq}, 8'h00);
            bus_read(1'b1, rd); check("R3 flag set", rd, 8'h01);
        end

        // R8 zero multiplier
        bus_write(1'b0, 8'h00); ticks(200);
        check("R8 0x00 irq", {7'd0, irq}, 8'h00);
        bus_read(1'b1, rd); check("R8 0x00 flag", rd, 8'h00);
        bus_write(1'b0, 8'h03); ticks(300);
        check("R8 0x03 irq", {7'd0, irq}, 8'h00);
        bus_read(1'b1, rd); check("R8 0x03 flag", rd, 8'h00);

        // R5 restart by write and read
        bus_write(1'b0, 8'h09); ticks(5);
        bus_write(1'b0, 8'h09); ticks(6);
        bus_read(1'b0, rd); check("R5 cfg readback", rd, 8'h09);
        ticks(7);
        check("R5 no early expiry", {7'd0, irq}, 8'h00);
        ticks(1);
        check("R5 expiry after restart", {7'd0, irq}, 8'h01);

        // R10 flag write ignored while irq high
        bus_write(1'b1, 8'h00);
        check("R10 irq kept", {7'd0, irq}, 8'h01);
        check("R10 idle rdata", bus_rdata, 8'h00);

        // R6 cfg access drops irq, flag kept
        bus_read(1'b0, rd);
        check("R6 irq dropped", {7'd0, irq}, 8'h00);
        bus_read(1'b1, rd); check("R6 flag kept", rd, 8'h01);
        bus_read(1'b1, rd); check("R7 flag cleared", rd, 8'h00);

        // R7 R9 flag read clears irq, count continues
        bus_write(1'b0, 8'h05); ticks(4);
        check("R9 first expiry", {7'd0, irq}, 8'h01);
        bus_read(1'b1, rd); check("R7 flag read", rd, 8'h01);
        check("R7 irq cleared", {7'd0, irq}, 8'h00);
        ticks(3);
        check("R9 no early second", {7'd0, irq}, 8'h00);
        ticks(1);
        check("R9 second expiry", {7'd0, irq}, 8'h01);
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, rd); check("R10 flag write no clear", rd, 8'h01);

        // R1 mid-run reset
        bus_write(1'b0, 8'h04); ticks(1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        bus_read(1'b0, rd); check("R1 cfg after reset", rd, 8'h00);
        bus_read(1'b1, rd); check("R1 flag after reset", rd, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule